// File: doc/BRIEF.md
# Direct-Mapped Cache with Deferred Store Write

This block is the front end of a small direct-mapped data cache that completes every store in a single memory-stage cycle. In the cycle a store is accepted, only the tag is looked up. A store that hits does not touch the data array in that cycle. Its address and data are parked in a one-entry holding register instead. The parked word goes into the data array during the tag-check cycle of the next store that hits. As a result, tag lookup and data write never compete for the same cycle.

The cache uses write-through with no write allocation. Every accepted store is sent to the backing memory in the cycle it is accepted. A store that misses leaves the cache untouched. A load that hits returns its data one cycle after acceptance. If the load targets the parked word, the returned value comes from the holding register. A load that misses first retires the parked word into the array. It then refills the whole line from backing memory, one word at a time, and returns the requested word. An idle cycle with the flush input raised also retires the parked word.

The address is split as {tag, set index, word offset}, with the word offset in the least significant bits. The default configuration is an 8-bit word address, 16-bit data, 8 sets and 4 words per line.

Top module: `store_pipe_cache`

## Requirements
- R1: After reset the holding register is empty (`pend_valid`=0), `rsp_valid` is 0 and `req_ready` equals `mem_ready`.
- R2: While idle with `mem_ready`=1, a store is accepted in the cycle it is presented, including on consecutive cycles. Each accepted store drives `mem_req`=1 and `mem_we`=1 with its own address and data in that same cycle.
- R3: A store whose tag matches a valid line is placed in the holding register, and `pend_valid` is 1 in the following cycle.
- R4: When a store hit is accepted while an entry is parked, the parked word is written into the data array in that cycle. A later load of that address that hits returns the value.
- R5: A store that misses changes neither the holding register nor any line of the cache.
- R6: A load that hits produces `rsp_valid` one cycle after acceptance. If its address equals the parked entry's address, it returns the parked data.
- R7: A load miss empties the holding register in its accept cycle. It then reads the line's words from backing memory in ascending offset order starting at the line base, with one read outstanding, and `req_ready` is 0 until the response. The response carries the requested word.
- R8: A cycle with `flush`=1 in which no request is accepted writes the parked word into the array, and `pend_valid` is 0 in the next cycle.
- R9: Every load returns the value of the most recent store to that address, or the backing-memory value if the address has never been stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address {tag, set, offset} |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request accepted this cycle if req_valid |
| flush | input | 1 | Retire the parked store in an idle cycle |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Load data |
| pend_valid | output | 1 | Holding register occupied |
| mem_req | output | 1 | Backing-memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Backing-memory word address |
| mem_wdata | output | DATA_W | Backing-memory write data |
| mem_ready | input | 1 | Backing memory accepts mem_req this cycle |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | DATA_W | Read data |

## Verification
On every cycle, the assertions check the following:
- the data array never takes a parked-word write and a refill write together;
- the holding register is empty and requests are refused throughout a refill;
- a store hit fills the holding register;
- a store miss leaves it as it was;
- a flush in an idle cycle empties it;
- each accepted store reaches the memory port.

Some behaviours can only be shown by the bench's scenarios, which compare against a flat reference memory:
- the data a load returns, whether forwarded or retired into the array;
- the order of refill reads;
- the absence of stalls across back-to-back store hits.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_FILL_REQ  = 2'd1,
    ST_FILL_WAIT = 2'd2
  } fill_state_e;
endpackage

// File: rtl/spc_rst_sync.sv
module spc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/spc_tag_array.sv
module spc_tag_array #(
  parameter int SET_W = 3,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [TAG_W-1:0] upd_tag
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]  line_valid_q;
  logic [TAG_W-1:0] line_tag_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic set_upd;
    assign set_upd = upd_en && (upd_set == SET_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       line_valid_q[s] <= 1'b0;
      else if (set_upd) line_valid_q[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (set_upd) line_tag_q[s] <= upd_tag;
    end
  end

  assign lk_hit = line_valid_q[lk_set] && (line_tag_q[lk_set] == lk_tag);
endmodule

// File: rtl/spc_data_array.sv
module spc_data_array #(
  parameter int LOC_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [LOC_W-1:0]  rd_loc,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [LOC_W-1:0]  wr_loc,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << LOC_W;

  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_loc] <= wr_data;
  end

  assign rd_data = word_q[rd_loc];
endmodule

// File: rtl/spc_delay_buf.sv
module spc_delay_buf #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              park_en,
  input  logic [ADDR_W-1:0] park_addr,
  input  logic [DATA_W-1:0] park_data,
  input  logic              retire_req,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_match,
  output logic              held_valid,
  output logic [ADDR_W-1:0] held_addr,
  output logic [DATA_W-1:0] held_data,
  output logic              retire_we
);
  logic held_valid_d;

  always_comb begin
    held_valid_d = held_valid;
    if (park_en)         held_valid_d = 1'b1;
    else if (retire_req) held_valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_valid <= 1'b0;
    else        held_valid <= held_valid_d;
  end

  always_ff @(posedge clk) begin
    if (park_en) begin
      held_addr <= park_addr;
      held_data <= park_data;
    end
  end

  // A parked word leaves for the array whenever it is replaced or retired.
  assign retire_we   = held_valid && (park_en || retire_req);
  assign probe_match = held_valid && (held_addr == probe_addr);

  p_park_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    park_en |=> held_valid);
  p_retire_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_req && !park_en) |=> !held_valid);
endmodule

// File: rtl/store_pipe_cache.sv
module store_pipe_cache
  import spc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SET_W  = 3,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              flush,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              pend_valid,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int LOC_W = SET_W + OFF_W;

  logic rst_n_i;

  fill_state_e       state_q, state_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] miss_addr_q;
  logic [DATA_W-1:0] capt_q;
  logic [DATA_W-1:0] rsp_data_d;
  logic              rsp_valid_d;

  logic idle, accept, tag_hit;
  logic st_hit, st_miss, ld_hit, ld_miss, flush_idle;
  logic retire_req, retire_we, fwd_hit;
  logic refill_we, fill_last, capt_en;
  logic [ADDR_W-1:0] held_addr;
  logic [DATA_W-1:0] held_data, arr_rdata;
  logic              arr_we;
  logic [LOC_W-1:0]  arr_wloc;
  logic [DATA_W-1:0] arr_wdata;

  spc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  // Request classification
  assign idle       = (state_q == ST_IDLE);
  assign req_ready  = idle && mem_ready;
  assign accept     = req_valid && req_ready;
  assign st_hit     = accept && req_write && tag_hit;
  assign st_miss    = accept && req_write && !tag_hit;
  assign ld_hit     = accept && !req_write && tag_hit;
  assign ld_miss    = accept && !req_write && !tag_hit;
  assign flush_idle = idle && flush && !accept;
  assign retire_req = ld_miss || flush_idle;

  spc_tag_array #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n_i),
    .lk_set(req_addr[OFF_W +: SET_W]),
    .lk_tag(req_addr[ADDR_W-1 -: TAG_W]),
    .lk_hit(tag_hit),
    .upd_en(fill_last),
    .upd_set(miss_addr_q[OFF_W +: SET_W]),
    .upd_tag(miss_addr_q[ADDR_W-1 -: TAG_W])
  );

  spc_delay_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n_i),
    .park_en(st_hit), .park_addr(req_addr), .park_data(req_wdata),
    .retire_req(retire_req),
    .probe_addr(req_addr), .probe_match(fwd_hit),
    .held_valid(pend_valid), .held_addr(held_addr), .held_data(held_data),
    .retire_we(retire_we)
  );

  // Array write port: parked word (idle only) or refill word (fill only)
  assign refill_we = (state_q == ST_FILL_WAIT) && mem_rvalid;
  assign fill_last = refill_we && (&cnt_q);
  assign capt_en   = refill_we && (cnt_q == miss_addr_q[OFF_W-1:0]);
  assign arr_we    = retire_we || refill_we;
  assign arr_wloc  = retire_we ? held_addr[LOC_W-1:0]
                               : {miss_addr_q[OFF_W +: SET_W], cnt_q};
  assign arr_wdata = retire_we ? held_data : mem_rdata;

  spc_data_array #(.LOC_W(LOC_W), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .rd_loc(req_addr[LOC_W-1:0]), .rd_data(arr_rdata),
    .wr_en(arr_we), .wr_loc(arr_wloc), .wr_data(arr_wdata)
  );

  // Backing-memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = req_addr;
    mem_wdata = req_wdata;
    if (idle && req_valid && req_write) begin
      mem_req = 1'b1;
      mem_we  = 1'b1;
    end else if (state_q == ST_FILL_REQ) begin
      mem_req  = 1'b1;
      mem_addr = {miss_addr_q[ADDR_W-1:OFF_W], cnt_q};
    end
  end

  // Refill sequencing
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (ld_miss) begin
          state_d = ST_FILL_REQ;
          cnt_d   = '0;
        end
      end
      ST_FILL_REQ: begin
        if (mem_ready) state_d = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (mem_rvalid) begin
          if (&cnt_q) state_d = ST_IDLE;
          else begin
            cnt_d   = cnt_q + 1'b1;
            state_d = ST_FILL_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Response selection
  always_comb begin
    rsp_valid_d = ld_hit || fill_last;
    if (ld_hit)       rsp_data_d = fwd_hit ? held_data : arr_rdata;
    else if (capt_en) rsp_data_d = mem_rdata;
    else              rsp_data_d = capt_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      rsp_valid <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_miss)     miss_addr_q <= req_addr;
    if (capt_en)     capt_q      <= mem_rdata;
    if (rsp_valid_d) rsp_data    <= rsp_data_d;
  end

  // Assertions
  p_one_writer_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(retire_we && refill_we));
  p_park_retires_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (st_hit && pend_valid) |-> retire_we);
  p_fill_empty_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    !idle |-> (!pend_valid && !req_ready));
  p_store_to_mem_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (accept && req_write) |-> (mem_req && mem_we && mem_addr == req_addr));
  p_hit_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    ld_hit |=> rsp_valid);
  p_miss_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    st_miss |=> $stable(pend_valid));
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    flush_idle |=> !pend_valid);
endmodule

// File: tb/store_pipe_cache_test.sv
module store_pipe_cache_test;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int MEMW   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, flush;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic req_ready, rsp_valid, pend_valid;
  logic [DATA_W-1:0] rsp_data;
  logic mem_req, mem_we, mem_ready, mem_rvalid;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  logic [DATA_W-1:0] bmem    [MEMW];
  logic [DATA_W-1:0] ref_mem [MEMW];
  logic [ADDR_W-1:0] rd_log  [64];
  int rd_n = 0;
  int checks = 0, errors = 0, cyc = 0;
  bit rnd_ready = 0;
  bit done = 0;

  always #10 clk = ~clk;

  store_pipe_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pend_valid(pend_valid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [DATA_W-1:0] init_val(input int a);
    return DATA_W'(a * 257) ^ 16'h5a3c;
  endfunction

  // Backing memory model: one-cycle read latency
  always @(posedge clk) begin
    mem_rvalid <= mem_req && mem_ready && !mem_we;
    if (mem_req && mem_ready) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else begin
        mem_rdata        <= bmem[mem_addr];
        rd_log[rd_n % 64] <= mem_addr;
        rd_n             <= rd_n + 1;
      end
    end
  end

  always @(negedge clk) mem_ready <= rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called just after a negedge; returns just after a negedge.
  task automatic do_req(input logic w, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d,
                        output logic [DATA_W-1:0] rd, output int stalls,
                        output int lat, output int busy_ready);
    stalls = 0; lat = 0; busy_ready = 0; rd = '0;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1; stalls++;
    end
    @(posedge clk);
    if (w) ref_mem[a] = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (!w) begin
      lat = 1;
      while (!rsp_valid && lat < 400) begin
        if (req_ready) busy_ready++;
        @(negedge clk); lat++;
      end
      rd = rsp_data;
    end
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    logic [DATA_W-1:0] rd;
    int st, lt, br, s0;
    for (int i = 0; i < MEMW; i++) begin
      bmem[i]    = init_val(i);
      ref_mem[i] = init_val(i);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; flush = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pend_valid", pend_valid, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);

    // R7 load miss: refill order, busy, requested word
    s0 = rd_n;
    do_req(1'b0, 8'h12, '0, rd, st, lt, br);
    chk("R7 miss data", rd, init_val(8'h12));
    chk("R7 read count", rd_n - s0, 4);
    for (int i = 0; i < 4; i++)
      chk("R7 read order", rd_log[(s0 + i) % 64], 8'h10 + i);
    chk("R7 ready low during fill", br, 0);

    // R3 store hit parks, R2 memory write
    do_req(1'b1, 8'h11, 16'hAAAA, rd, st, lt, br);
    chk("R3 parked", pend_valid, 1);
    chk("R2 store no stall", st, 0);
    chk("R2 memory written", bmem[8'h11], 16'hAAAA);

    // R6 forward from held entry, 1-cycle latency
    do_req(1'b0, 8'h11, '0, rd, st, lt, br);
    chk("R6 forward data", rd, 16'hAAAA);
    chk("R6 hit latency", lt, 1);

    // R4 next store hit retires the first into the array
    do_req(1'b1, 8'h12, 16'hBBBB, rd, st, lt, br);
    do_req(1'b0, 8'h11, '0, rd, st, lt, br);
    chk("R4 retired word", rd, 16'hAAAA);

    // R5 store miss leaves holding register and cache alone
    do_req(1'b1, 8'h80, 16'hCCCC, rd, st, lt, br);
    chk("R5 pend kept", pend_valid, 1);
    chk("R2 miss store to memory", bmem[8'h80], 16'hCCCC);
    do_req(1'b0, 8'h12, '0, rd, st, lt, br);
    chk("R5 held entry intact", rd, 16'hBBBB);
    do_req(1'b0, 8'h80, '0, rd, st, lt, br);
    chk("R5 no allocate (refill seen)", lt > 2, 1);
    chk("R5 miss store data", rd, 16'hCCCC);

    // R8 flush in idle cycle
    do_req(1'b1, 8'h13, 16'hDDDD, rd, st, lt, br);
    chk("R8 pend before", pend_valid, 1);
    do_flush();
    chk("R8 flushed", pend_valid, 0);
    do_req(1'b0, 8'h13, '0, rd, st, lt, br);
    chk("R8 data after flush", rd, 16'hDDDD);

    // R7 load miss drains held entry
    do_req(1'b1, 8'h10, 16'hEEEE, rd, st, lt, br);
    do_req(1'b0, 8'h45, '0, rd, st, lt, br);
    chk("R7 drained on miss", pend_valid, 0);
    chk("R7 other miss data", rd, init_val(8'h45));
    do_req(1'b0, 8'h10, '0, rd, st, lt, br);
    chk("R7 drained word kept", rd, 16'hEEEE);

    // R2 back-to-back store hits, no stalls
    for (int i = 0; i < 4; i++) begin
      do_req(1'b1, 8'h44 + i, 16'h1000 + i, rd, st, lt, br);
      chk("R2 back-to-back stall", st, 0);
    end
    for (int i = 0; i < 4; i++) begin
      do_req(1'b0, 8'h44 + i, '0, rd, st, lt, br);
      chk("R9 back-to-back data", rd, 16'h1000 + i);
    end

    // R9 full sweep: store every address, then load every address
    for (int a = 0; a < MEMW; a++)
      do_req(1'b1, a[7:0], DATA_W'(a) ^ 16'hBEEF, rd, st, lt, br);
    for (int a = 0; a < MEMW; a++) begin
      do_req(1'b0, a[7:0], '0, rd, st, lt, br);
      chk("R9 sweep", rd, ref_mem[a]);
    end

    // R9 mixed traffic with stalling memory
    rnd_ready = 1;
    for (int n = 0; n < 1500; n++) begin
      logic [ADDR_W-1:0] a;
      a = ($urandom_range(0, 3) == 0) ? ADDR_W'($urandom_range(0, 255))
                                     : ADDR_W'($urandom_range(0, 47));
      case ($urandom_range(0, 5))
        0, 1, 2: do_req(1'b1, a, DATA_W'($urandom), rd, st, lt, br);
        3: do_flush();
        default: begin
          do_req(1'b0, a, '0, rd, st, lt, br);
          chk("R9 mixed", rd, ref_mem[a]);
        end
      endcase
    end
    rnd_ready = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule